// File: doc/BRIEF.md
# Padded Vertex Count Calculator

This block turns an unsigned vertex count into the padded thread count used when vertices are dispatched for instanced drawing. Padding the count to a value of the form f × 2^s, with f one of 1, 3, 5, 7 or 9, keeps the later split of a linear thread index into (vertex, instance) cheap. That split needs only a shift plus a division by a small odd constant. It also wastes far fewer threads than padding to the next power of two.

A count is presented together with a one-cycle valid strobe. One clock later the block raises a one-cycle valid pulse with three results:

- the padded count;
- the odd-factor selector m, where the factor is 2m+1;
- the shift n, so that padded = (2m+1) × 2^n.

Counts of 32 and above are handled from the leading one and the three bits below it. Smaller counts are rounded up to the next multiple of four.

Top module: `vtx_pad_calc`

## Requirements
- R1: While `rst` is high, on the following clock `out_valid` is 0 and `out_padded`, `out_odd_sel` and `out_shift` are all 0.
- R2: `out_valid` is 1 in exactly the cycles that follow a clock edge at which `in_valid` was 1, which gives one cycle of latency.
- R3: Every reported padded count is strictly greater than the count it was computed from, including counts that already have the allowed form.
- R4: Every reported padded count is a multiple of four and equals (2 × `out_odd_sel` + 1) × 2^`out_shift`, with `out_odd_sel` in 0..4 and `out_shift` at least 2.
- R5: For a count c below 32, the padded count is (c with its two low bits cleared) + 4. A count of 0 gives padded 4, m = 0, n = 2.
- R6: For a count of 32 or more, let h be the 4-bit value made of the leading one and the three bits below it, and let e be the number of bits below those four. The padded count is t × 2^e, where t is 9 for h = 8, 10 for h = 9, 12 for h = 10 or 11, 14 for h = 12 or 13, and 16 for h = 14 or 15. For example, 70 gives 72 with m = 4 and n = 3.
- R7: The all-ones count 2^32 − 1 gives padded 2^32 with m = 0 and n = 32, so the padded output is one bit wider than the count.
- R8: The padded count is the smallest value of the form f × 2^s, with f in {1,3,5,7,9} and s ≥ 2, that is greater than the count.
- R9: In a cycle after an edge with `in_valid` low, `out_padded`, `out_odd_sel` and `out_shift` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe qualifying `in_count` |
| in_count | input | 32 | Unsigned vertex count |
| out_valid | output | 1 | One-cycle pulse, one clock after `in_valid` |
| out_padded | output | 33 | Padded thread count |
| out_odd_sel | output | 3 | Odd-factor selector m, factor = 2m+1 |
| out_shift | output | 6 | Power-of-two shift n |

## Verification
Every count from 0 to 300 is applied. This separates the multiple-of-four path used below 32 from the table path above it, and visits every table row at small exponents. Powers of two and their neighbours (2^k − 1, 2^k, 2^k + 1) probe the edges where the leading one moves and where an input already of the allowed form must still be padded upward. The all-ones count checks the carry into the extra output bit. Pseudo-random counts scaled across all magnitudes, sent with idle gaps between them, are compared against a brute-force search for the smallest allowed value, which also checks that the outputs hold while no strobe arrives.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

    localparam int TGT_W  = 5;   // rounded target 1..16
    localparam int ODD_W  = 3;   // odd selector 0..4
    localparam int KSH_W  = 3;   // trailing zeros of target 0..4
    localparam int HIGH_W = 4;   // leading one plus three bits
    localparam int SMALL_EXP = 2;
    localparam int SMALL_LIMIT_POS = 5;  // leading one at bit 5 or above -> table path

    typedef enum logic {
        RANGE_SMALL = 1'b0,
        RANGE_LARGE = 1'b1
    } range_e;

    typedef struct packed {
        logic [ODD_W-1:0] odd_sel;
        logic [KSH_W-1:0] ksh;
    } target_split_t;

    // Round the normalised high value up to the allowed target.
    function automatic logic [TGT_W-1:0] round_target(logic [HIGH_W-1:0] q, range_e cls);
        logic [TGT_W-1:0] t;
        if (cls == RANGE_SMALL) begin
            t = TGT_W'(q) + TGT_W'(1);
        end else begin
            case (q)
                4'd8:          t = 5'd9;
                4'd9:          t = 5'd10;
                4'd10, 4'd11:  t = 5'd12;
                4'd12, 4'd13:  t = 5'd14;
                default:       t = 5'd16;
            endcase
        end
        return t;
    endfunction

    // Split target into odd factor selector and power-of-two part.
    function automatic target_split_t split_target(logic [TGT_W-1:0] t);
        target_split_t r;
        logic [KSH_W-1:0] tz;
        logic found;
        tz = '0;
        found = 1'b0;
        for (int i = 0; i < TGT_W; i++) begin
            if (!found) begin
                if (t[i]) found = 1'b1;
                else      tz = tz + KSH_W'(1);
            end
        end
        r.ksh = tz;
        r.odd_sel = ODD_W'((t >> tz) >> 1);
        return r;
    endfunction

endpackage

// File: rtl/pvc_lead_one.sv
module pvc_lead_one #(
    parameter int W     = 32,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [POS_W-1:0] pos
);
    // Highest set bit wins; zero input reports position 0.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/pvc_round.sv
module pvc_round
    import pvc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int POS_W = $clog2(CNT_W)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [POS_W-1:0] msb_pos,
    output logic [TGT_W-1:0] target,
    output logic [POS_W-1:0] expo
);
    range_e              cls;
    logic [HIGH_W-1:0]   high;

    always_comb begin
        cls  = (msb_pos >= POS_W'(SMALL_LIMIT_POS)) ? RANGE_LARGE : RANGE_SMALL;
        expo = (cls == RANGE_LARGE) ? (msb_pos - POS_W'(HIGH_W - 1)) : POS_W'(SMALL_EXP);
        high = count[expo +: HIGH_W];
        target = round_target(high, cls);
    end

    // R6: on the table path the normalised high value carries its leading one
    always_comb begin
        a_r6_high_norm: assert (cls == RANGE_SMALL || high[HIGH_W-1]);
    end
endmodule

// File: rtl/pvc_encode.sv
module pvc_encode
    import pvc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int POS_W   = $clog2(CNT_W),
    parameter int SHIFT_W = $clog2(CNT_W + 1),
    parameter int PAD_W   = CNT_W + 1
) (
    input  logic [TGT_W-1:0]   target,
    input  logic [POS_W-1:0]   expo,
    output logic [PAD_W-1:0]   padded,
    output logic [ODD_W-1:0]   odd_sel,
    output logic [SHIFT_W-1:0] shift
);
    target_split_t sp;

    always_comb begin
        sp      = split_target(target);
        padded  = PAD_W'(target) << expo;
        odd_sel = sp.odd_sel;
        shift   = SHIFT_W'(expo) + SHIFT_W'(sp.ksh);
    end
endmodule

// File: rtl/vtx_pad_calc.sv
module vtx_pad_calc
    import pvc_pkg::*;
#(
    parameter int CNT_W = 32,
    localparam int POS_W   = $clog2(CNT_W),
    localparam int SHIFT_W = $clog2(CNT_W + 1),
    localparam int PAD_W   = CNT_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [CNT_W-1:0]   in_count,
    output logic               out_valid,
    output logic [PAD_W-1:0]   out_padded,
    output logic [ODD_W-1:0]   out_odd_sel,
    output logic [SHIFT_W-1:0] out_shift
);
    logic [POS_W-1:0]   msb_pos;
    logic [TGT_W-1:0]   target;
    logic [POS_W-1:0]   expo;
    logic [PAD_W-1:0]   pad_c;
    logic [ODD_W-1:0]   odd_c;
    logic [SHIFT_W-1:0] shift_c;

    pvc_lead_one #(.W(CNT_W), .POS_W(POS_W)) u_lead (
        .vec (in_count),
        .pos (msb_pos)
    );

    pvc_round #(.CNT_W(CNT_W), .POS_W(POS_W)) u_round (
        .count   (in_count),
        .msb_pos (msb_pos),
        .target  (target),
        .expo    (expo)
    );

    pvc_encode #(.CNT_W(CNT_W), .POS_W(POS_W), .SHIFT_W(SHIFT_W), .PAD_W(PAD_W)) u_enc (
        .target  (target),
        .expo    (expo),
        .padded  (pad_c),
        .odd_sel (odd_c),
        .shift   (shift_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_padded  <= '0;
            out_odd_sel <= '0;
            out_shift   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_padded  <= pad_c;
                out_odd_sel <= odd_c;
                out_shift   <= shift_c;
            end
        end
    end

    // R1: reset clears the outputs
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!out_valid && out_padded == '0 && out_odd_sel == '0 && out_shift == '0));

    // R2: pulse follows the strobe by one cycle
    a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R3: result is strictly above the count
    a_r3_above: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_padded > $past(PAD_W'(in_count))));

    // R4: result shape
    a_r4_shape: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_padded[1:0] == 2'b00 && out_odd_sel <= ODD_W'(4)
                       && out_shift >= SHIFT_W'(2)));

    // R9: outputs hold without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_padded) && $stable(out_odd_sel) && $stable(out_shift)));
endmodule

// File: tb/test_vtx_pad_calc.sv
`timescale 1ns/1ps
module test_vtx_pad_calc;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_count;
    logic        out_valid;
    logic [32:0] out_padded;
    logic [2:0]  out_odd_sel;
    logic [5:0]  out_shift;

    int checks = 0;
    int failures = 0;

    longint exp_pad = 0;
    int     exp_m = 0;
    int     exp_n = 0;
    bit     exp_valid = 0;

    always #2.5 clk = ~clk;

    vtx_pad_calc i_vtx_pad_calc (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_count    (in_count),
        .out_valid   (out_valid),
        .out_padded  (out_padded),
        .out_odd_sel (out_odd_sel),
        .out_shift   (out_shift)
    );

    // Brute-force search for smallest allowed value above c (R8)
    function automatic longint ref_pad(longint c);
        longint best = 64'h7fff_ffff_ffff_ffff;
        for (int s = 2; s < 40; s++) begin
            for (int f = 1; f <= 9; f += 2) begin
                longint p;
                p = longint'(f) << s;
                if (p > c && p < best) best = p;
            end
        end
        return best;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic compare(string tag_pad);
        chk(out_valid == exp_valid, "R2 valid", longint'(out_valid), longint'(exp_valid));
        chk(longint'(out_padded) == exp_pad, tag_pad, longint'(out_padded), exp_pad);
        chk(int'(out_odd_sel) == exp_m, {tag_pad, " odd_sel"}, longint'(out_odd_sel), longint'(exp_m));
        chk(int'(out_shift) == exp_n, {tag_pad, " shift"}, longint'(out_shift), longint'(exp_n));
    endtask

    task automatic apply(bit v, logic [31:0] c);
        string tag;
        longint cl;
        in_valid = v;
        in_count = c;
        @(posedge clk);
        cl = longint'(c);
        if (v) begin
            longint p;
            int tz;
            p = ref_pad(cl);
            tz = 0;
            while (((p >> tz) & 1) == 0) tz++;
            exp_pad = p;
            exp_n = tz;
            exp_m = int'(((p >> tz) - 1) / 2);
            exp_valid = 1;
            if (c == 32'hffff_ffff) tag = "R7,R8";
            else if (c < 32)        tag = "R5,R8";
            else                    tag = "R6,R8";
        end else begin
            exp_valid = 0;
            tag = "R9 hold";
        end
        @(negedge clk);
        compare(tag);
        if (v) begin
            chk(longint'(out_padded) > cl, "R3 above", longint'(out_padded), cl + 1);
            chk((longint'(out_padded) % 4) == 0 &&
                ((longint'(2 * out_odd_sel + 1)) << out_shift) == longint'(out_padded),
                "R4 form", longint'(out_padded),
                (longint'(2 * out_odd_sel + 1)) << out_shift);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        in_count = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        exp_valid = 0; exp_pad = 0; exp_m = 0; exp_n = 0;
        compare("R1 reset");
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] x;
        rst = 1'b1;
        in_valid = 1'b0;
        in_count = '0;
        @(negedge clk);
        do_reset();

        // R5 zero and R6 worked example
        apply(1'b1, 32'd0);
        chk(out_padded == 33'd4 && out_odd_sel == 3'd0 && out_shift == 6'd2,
            "R5 zero", longint'(out_padded), 4);
        apply(1'b1, 32'd70);
        chk(out_padded == 33'd72 && out_odd_sel == 3'd4 && out_shift == 6'd3,
            "R6 seventy", longint'(out_padded), 72);

        // Full sweep of low counts, with idle cycles for R9
        for (int i = 0; i <= 300; i++) begin
            apply(1'b1, 32'(i));
            if (i % 7 == 0) apply(1'b0, 32'hdead_beef);
        end

        // Powers of two and neighbours
        for (int k = 0; k < 32; k++) begin
            logic [31:0] pw;
            pw = 32'd1 << k;
            apply(1'b1, pw - 32'd1);
            apply(1'b1, pw);
            apply(1'b1, pw + 32'd1);
        end

        // R7 largest count
        apply(1'b1, 32'hffff_ffff);
        chk(out_padded == 33'h1_0000_0000 && out_odd_sel == 3'd0 && out_shift == 6'd32,
            "R7 max", longint'(out_padded), 64'h1_0000_0000);
        apply(1'b0, 32'd5);

        // Pseudo-random counts over all magnitudes
        x = 32'h1234_5678;
        for (int i = 0; i < 3000; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            apply(1'b1, x >> (x[4:0]));
            if (x[7:5] == 3'd0) apply(1'b0, x);
        end

        // Mid-run reset, then resume
        apply(1'b1, 32'd1000);
        do_reset();
        apply(1'b0, 32'd9);
        apply(1'b1, 32'd31);
        apply(1'b1, 32'd32);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule